// File: doc/BRIEF.md
# GPU L1 Line State Controller

This block keeps the per-line state of a small write-combining L1 data cache for a GPU core. Core requests are loads, write-back stores, spill (scratch) stores, store-throughs, atomics, flushes and acquire-style evictions. Responses from the next cache level are fills and write acknowledges. Every line holds one of six states: Invalid, Valid (clean fill), Written (dirty bytes, no fill), Modified (dirty bytes over a fill), Local (spill data) and Atomic-pending. There is no ownership protocol. Dirty bytes reach the next level only by write-through, which happens on flush, replacement, an atomic to a dirty line, or a store-through.

The tag and data storage is a direct-mapped array of `LINES` lines, each `LINE_BYTES` wide, with a per-byte dirty mask. Outgoing messages are read-block, write-through (with byte mask) and atomic. Each message carries a destination bank taken from the address bits just above the line offset. Callbacks to the core are registered single-cycle pulses.

Each cycle the block accepts at most one response and one request, and never both. Every output appears one clock after the input that causes it. A request that cannot complete in one cycle is held back through `req_ready` and retried. Examples are a load to a Written line, an atomic to a dirty line, and an allocation whose slot holds another line.

Top module: `gpu_l1_line_ctrl`

## Requirements
- R1: When `rsp_valid` is high, no request is accepted in that cycle (`req_ready` low), and the response is handled first. Each accepted item produces at most one callback among load-done, store-done and invalidate-done.
- R2: While a line is Atomic-pending, a load, store, spill store, store-through or atomic to it is not accepted (`req_ready` stays low).
- R3: After reset all lines are Invalid and no message or callback is raised. A load to a Valid, Modified or Local line gives `load_done` with the line data one cycle after acceptance. A load that misses issues a read-block (`msg_kind` 0) and leaves the line Invalid. A load to a Written line first writes the line through, invalidates it and is then retried as a miss.
- R4: A fill (`rsp_wback` 0) to an Invalid line allocates it as Valid. A fill to a Written or Modified line keeps the dirty bytes over the fill data and makes the line Modified. Fills to these lines raise `load_done` with the resulting data. A fill to an Atomic-pending line raises `store_done` and leaves the line Invalid.
- R5: With `wb_mode` high, a store (`req_op` 1) to an Invalid line allocates it as Written, and a store to a Valid line makes it Modified. Mask bit b selects byte b, data bits [8b+7:8b]. An allocated line starts from zero data, and `store_done` is raised.
- R6: A spill store (`req_op` 2) to an Invalid, Valid or Local line leaves it Local. A store-through (`req_op` 3) merges its bytes into a hit line and issues a write-through (`msg_kind` 1) whose mask is the line mask OR the request mask. It then raises `store_done` and invalidates the line.
- R7: An atomic (`req_op` 4) to an Invalid or Valid line issues an atomic message (`msg_kind` 2) with the request data and mask and makes the line Atomic-pending. An atomic to a Written, Modified or Local line first writes the line through and invalidates it, and is then retried.
- R8: When a store, spill store, atomic or fill needs a slot held by another line, a dirty victim is written through at its own address, and a clean victim is dropped silently. The original item is retried in the next cycle.
- R9: A flush (`req_op` 5) writes a Written or Modified line through and invalidates it. `flush_done` pulses once the count of unacknowledged write-throughs (decremented by `rsp_wback` 1) is zero.
- R10: An evict (`req_op` 6) makes a Valid line Invalid and a Modified line Written. It leaves Written, Local and Atomic-pending lines unchanged, and it always raises `inv_done`.
- R11: With `l1_off` high, every store and spill store acts as a store-through. A fill not aimed at an Atomic-pending line raises `load_done` with the fill data and allocates nothing.
- R12: `msg_bank` equals bits [OFF+BANK_BITS-1:OFF] of `msg_addr`, where OFF is log2 of `LINE_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1: stores are write-back; 0: stores are store-through |
| l1_off | input | 1 | Bypass: stores go through, fills are not kept |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_op | input | 3 | 0 load, 1 store, 2 spill store, 3 store-through, 4 atomic, 5 flush, 6 evict |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 8*LINE_BYTES | Store or atomic data |
| req_mask | input | LINE_BYTES | Byte enables |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response accepted this cycle |
| rsp_wback | input | 1 | 1: write acknowledge, 0: fill |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_data | input | 8*LINE_BYTES | Fill data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_kind | output | 2 | 0 read-block, 1 write-through, 2 atomic |
| msg_addr | output | ADDR_W | Line address of the message |
| msg_bank | output | BANK_BITS | Destination bank |
| msg_data | output | 8*LINE_BYTES | Write-through or atomic data |
| msg_mask | output | LINE_BYTES | Byte mask |
| load_done | output | 1 | Load completed, data on done_data |
| store_done | output | 1 | Store or atomic completed |
| inv_done | output | 1 | Evict completed |
| flush_done | output | 1 | Flush completed |
| done_addr | output | ADDR_W | Line address of the callback |
| done_data | output | 8*LINE_BYTES | Load data |

## Verification
The assertions check a few properties on every cycle: responses block requests, load/store/invalidate callbacks are mutually exclusive, a read-block never comes with load data in the same cycle, and `flush_done` fires only with no write-through outstanding. The state walk needs the bench's scenarios. Those scenarios cover merges of dirty bytes over fills, victim write-through before a retried allocation, the two-step write-through-then-retry of loads and atomics on dirty lines, the stall on an Atomic-pending line, and bypass behaviour. The byte-exact contents of messages and callbacks are visible only there.

// File: rtl/gpu_l1_line_ctrl.sv
module gpu_l1_line_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 4,
  parameter int LINES      = 4,
  parameter int BANK_BITS  = 2,
  parameter int CNT_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wb_mode,
  input  logic                    l1_off,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [8*LINE_BYTES-1:0] req_wdata,
  input  logic [LINE_BYTES-1:0]   req_mask,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic                    rsp_wback,
  input  logic [ADDR_W-1:0]       rsp_addr,
  input  logic [8*LINE_BYTES-1:0] rsp_data,
  output logic                    msg_valid,
  output logic [1:0]              msg_kind,
  output logic [ADDR_W-1:0]       msg_addr,
  output logic [BANK_BITS-1:0]    msg_bank,
  output logic [8*LINE_BYTES-1:0] msg_data,
  output logic [LINE_BYTES-1:0]   msg_mask,
  output logic                    load_done,
  output logic                    store_done,
  output logic                    inv_done,
  output logic                    flush_done,
  output logic [ADDR_W-1:0]       done_addr,
  output logic [8*LINE_BYTES-1:0] done_data
);
  localparam int OFF   = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF - IDX_W;
  localparam int DW    = 8 * LINE_BYTES;

  localparam logic [2:0] S_I = 3'd0, S_V = 3'd1, S_W = 3'd2, S_M = 3'd3, S_L = 3'd4, S_A = 3'd5;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_SPILL = 3'd2, OP_THRU = 3'd3,
                         OP_ATOM = 3'd4, OP_FLUSH = 3'd5, OP_EVICT = 3'd6;
  localparam logic [1:0] K_RD = 2'd0, K_WT = 2'd1, K_AT = 2'd2;

  logic [2:0]            st  [LINES];
  logic [TAG_W-1:0]      tg  [LINES];
  logic [DW-1:0]         dat [LINES];
  logic [LINE_BYTES-1:0] msk [LINES];
  logic [CNT_W-1:0]      wt_cnt;
  logic                  flush_pend;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] nw, input logic [DW-1:0] old,
                                          input logic [LINE_BYTES-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < LINE_BYTES; b++) r[8*b +: 8] = m[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  wire [ADDR_W-1:0]     a_sel  = rsp_valid ? rsp_addr : req_addr;
  wire [IDX_W-1:0]      ix     = a_sel[OFF +: IDX_W];
  wire [TAG_W-1:0]      tq     = a_sel[ADDR_W-1 -: TAG_W];
  wire [ADDR_W-1:0]     a_line = {a_sel[ADDR_W-1:OFF], {OFF{1'b0}}};
  wire                  hit    = (st[ix] != S_I) && (tg[ix] == tq);
  wire [2:0]            cs     = hit ? st[ix] : S_I;
  wire                  other  = (st[ix] != S_I) && !hit;
  wire [DW-1:0]         cur_d  = hit ? dat[ix] : '0;
  wire [LINE_BYTES-1:0] cur_m  = hit ? msk[ix] : '0;
  wire                  dirty  = (cs == S_W) || (cs == S_M) || (cs == S_L);
  wire                  is_st  = (req_op == OP_ST) || (req_op == OP_SPILL);
  wire [2:0]            eop    = (is_st && (l1_off || (req_op == OP_ST && !wb_mode))) ? OP_THRU : req_op;
  wire                  blocked = (cs == S_A) && (req_op != OP_FLUSH) && (req_op != OP_EVICT);

  logic                  vict, m_v, d_ld, d_st, d_inv, w_en, wt_dec, fl_set;
  logic [1:0]            m_k;
  logic [ADDR_W-1:0]     m_a;
  logic [DW-1:0]         m_d, d_dat, w_d;
  logic [LINE_BYTES-1:0] m_m, w_m;
  logic [2:0]            w_st;

  always_comb begin
    req_ready = 1'b0; rsp_ready = 1'b0; vict = 1'b0;
    m_v = 1'b0; m_k = K_RD; m_a = a_line; m_d = '0; m_m = '0;
    d_ld = 1'b0; d_st = 1'b0; d_inv = 1'b0; d_dat = cur_d;
    w_en = 1'b0; w_st = cs; w_d = cur_d; w_m = cur_m;
    wt_dec = 1'b0; fl_set = 1'b0;
    if (rsp_valid) begin
      if (rsp_wback) begin
        rsp_ready = 1'b1; wt_dec = 1'b1;
      end else if (cs == S_A) begin
        rsp_ready = 1'b1; d_st = 1'b1; w_en = 1'b1; w_st = S_I;
      end else if (l1_off || (other && st[ix] == S_A)) begin
        rsp_ready = 1'b1; d_ld = 1'b1; d_dat = rsp_data;
      end else if (other) begin
        vict = 1'b1;
      end else begin
        rsp_ready = 1'b1; d_ld = 1'b1; w_en = 1'b1;
        w_d   = merge(cur_d, rsp_data, cur_m);
        w_st  = (cs == S_I || cs == S_V) ? S_V : (cs == S_L ? S_L : S_M);
        d_dat = w_d;
      end
    end else if (req_valid && !blocked) begin
      case (eop)
        OP_LD:
          if (cs == S_W) begin
            m_v = 1'b1; m_k = K_WT; m_d = cur_d; m_m = cur_m; w_en = 1'b1; w_st = S_I;
          end else begin
            req_ready = 1'b1;
            if (cs == S_I) m_v = 1'b1;
            else d_ld = 1'b1;
          end
        OP_ST, OP_SPILL:
          if (other) vict = (st[ix] != S_A);
          else begin
            req_ready = 1'b1; d_st = 1'b1; w_en = 1'b1;
            w_d = merge(req_wdata, cur_d, req_mask);
            w_m = cur_m | req_mask;
            if (eop == OP_SPILL && (cs == S_I || cs == S_V || cs == S_L)) w_st = S_L;
            else if (cs == S_I) w_st = S_W;
            else if (cs == S_V) w_st = S_M;
          end
        OP_THRU: begin
          req_ready = 1'b1; d_st = 1'b1; m_v = 1'b1; m_k = K_WT;
          m_d = merge(req_wdata, cur_d, req_mask);
          m_m = cur_m | req_mask;
          if (hit) begin w_en = 1'b1; w_st = S_I; end
        end
        OP_ATOM:
          if (dirty) begin
            m_v = 1'b1; m_k = K_WT; m_d = cur_d; m_m = cur_m; w_en = 1'b1; w_st = S_I;
          end else if (other) vict = (st[ix] != S_A);
          else begin
            req_ready = 1'b1; m_v = 1'b1; m_k = K_AT; m_d = req_wdata; m_m = req_mask;
            w_en = 1'b1; w_st = S_A;
          end
        OP_FLUSH: begin
          req_ready = 1'b1; fl_set = 1'b1;
          if (cs == S_W || cs == S_M) begin
            m_v = 1'b1; m_k = K_WT; m_d = cur_d; m_m = cur_m; w_en = 1'b1; w_st = S_I;
          end
        end
        OP_EVICT: begin
          req_ready = 1'b1; d_inv = 1'b1;
          if (cs == S_V) begin w_en = 1'b1; w_st = S_I; end
          else if (cs == S_M) begin w_en = 1'b1; w_st = S_W; end
        end
        default: req_ready = 1'b1;
      endcase
    end
    if (vict) begin
      w_en = 1'b1; w_st = S_I;
      if (st[ix] != S_V) begin
        m_v = 1'b1; m_k = K_WT; m_a = {tg[ix], ix, {OFF{1'b0}}}; m_d = dat[ix]; m_m = msk[ix];
      end
    end
  end

  wire              wt_inc = m_v && (m_k == K_WT);
  wire [CNT_W-1:0]  cnt_n  = wt_cnt + CNT_W'(wt_inc) - CNT_W'(wt_dec && (wt_cnt != 0 || wt_inc));
  wire              fp_n   = flush_pend | fl_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= S_I;
      msg_valid <= 1'b0; msg_kind <= K_RD; msg_addr <= '0; msg_bank <= '0;
      msg_data <= '0; msg_mask <= '0;
      load_done <= 1'b0; store_done <= 1'b0; inv_done <= 1'b0; flush_done <= 1'b0;
      done_addr <= '0; done_data <= '0;
      wt_cnt <= '0; flush_pend <= 1'b0;
    end else begin
      if (w_en) st[ix] <= w_st;
      msg_valid <= m_v; msg_kind <= m_k; msg_addr <= m_a; msg_bank <= m_a[OFF +: BANK_BITS];
      msg_data <= m_d; msg_mask <= m_m;
      load_done <= d_ld; store_done <= d_st; inv_done <= d_inv;
      done_addr <= a_line; done_data <= d_dat;
      wt_cnt <= cnt_n;
      flush_done <= fp_n && (cnt_n == 0);
      flush_pend <= fp_n && (cnt_n != 0);
    end
  end

  always_ff @(posedge clk) begin
    if (w_en) begin
      tg[ix]  <= tq;
      dat[ix] <= w_d;
      msk[ix] <= w_m;
    end
  end

  a_r1_rsp_first: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready);
  a_r1_one_callback: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_done, store_done, inv_done}));
  a_r3_miss_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == K_RD) |-> !load_done);
  a_r9_flush_drained: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (wt_cnt == 0));
endmodule

// File: tb/gpu_l1_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpu_l1_line_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wb_mode = 1'b1, l1_off = 1'b0;
  logic req_valid = 1'b0, rsp_valid = 1'b0, rsp_wback = 1'b0;
  logic [2:0] req_op = '0;
  logic [11:0] req_addr = '0, rsp_addr = '0;
  logic [31:0] req_wdata = '0, rsp_data = '0;
  logic [3:0] req_mask = '0;
  logic req_ready, rsp_ready, msg_valid, load_done, store_done, inv_done, flush_done;
  logic [1:0] msg_kind, msg_bank;
  logic [11:0] msg_addr, done_addr;
  logic [31:0] msg_data, done_data;
  logic [3:0] msg_mask;
  int n_tests = 0, n_fail = 0;
  bit started = 1'b0;

  int exp_k[$]; logic [11:0] exp_a[$]; logic [31:0] exp_d[$]; logic [3:0] exp_m[$]; string exp_t[$];

  always #2 clk = ~clk;

  gpu_l1_line_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .l1_off(l1_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_wback(rsp_wback), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_bank(msg_bank),
    .msg_data(msg_data), .msg_mask(msg_mask),
    .load_done(load_done), .store_done(store_done), .inv_done(inv_done), .flush_done(flush_done),
    .done_addr(done_addr), .done_data(done_data));

  // kinds: 0 read-block, 1 write-through, 2 atomic, 3 load-done, 4 store-done, 5 inv-done, 6 flush-done
  task automatic expect_ev(int k, logic [11:0] a, logic [31:0] d, logic [3:0] m, string t);
    exp_k.push_back(k); exp_a.push_back(a); exp_d.push_back(d); exp_m.push_back(m); exp_t.push_back(t);
  endtask

  task automatic see(int k, logic [11:0] a, logic [31:0] d, logic [3:0] m, logic [1:0] bk);
    int ek; logic [11:0] ea; logic [31:0] ed; logic [3:0] em; string et; bit bad;
    n_tests++;
    if (exp_k.size() == 0) begin
      n_fail++;
      $display("FAIL R1 unexpected event: actual kind %0d addr %h data %h, expected none", k, a, d);
      return;
    end
    ek = exp_k.pop_front(); ea = exp_a.pop_front(); ed = exp_d.pop_front();
    em = exp_m.pop_front(); et = exp_t.pop_front();
    bad = (ek != k) || (k != 6 && ea != a) || (k <= 3 && ed != d) ||
          (k <= 2 && (em != m || bk != ea[3:2]));
    if (bad) begin
      n_fail++;
      $display("FAIL %s: actual kind %0d addr %h data %h mask %b bank %0d, expected kind %0d addr %h data %h mask %b bank %0d",
               et, k, a, d, m, bk, ek, ea, ed, em, ea[3:2]);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (msg_valid)  see(int'(msg_kind), msg_addr, msg_data, msg_mask, msg_bank);
      if (load_done)  see(3, done_addr, done_data, 4'h0, 2'd0);
      if (store_done) see(4, done_addr, done_data, 4'h0, 2'd0);
      if (inv_done)   see(5, done_addr, done_data, 4'h0, 2'd0);
      if (flush_done) see(6, done_addr, done_data, 4'h0, 2'd0);
    end
  end

  task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, expv);
    end
  endtask

  task automatic do_req(logic [2:0] op, logic [11:0] a, logic [31:0] d, logic [3:0] m);
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic do_rsp(logic wb, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    rsp_wback = wb; rsp_addr = a; rsp_data = d; rsp_valid = 1'b1;
    #1;
    while (!rsp_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msg_valid && !load_done && !store_done && !inv_done && !flush_done, "R3 reset idle",
        {27'd0, msg_valid, load_done, store_done, inv_done, flush_done}, 32'd0);
    started = 1'b1;

    expect_ev(0, 12'h100, 0, 0, "R3");               do_req(0, 12'h100, 0, 0);
    expect_ev(3, 12'h100, 32'h11223344, 0, "R4");    do_rsp(0, 12'h100, 32'h11223344);
    expect_ev(3, 12'h100, 32'h11223344, 0, "R3");    do_req(0, 12'h100, 0, 0);
    expect_ev(4, 12'h100, 0, 0, "R5");               do_req(1, 12'h100, 32'hAABBCCDD, 4'b0001);
    expect_ev(3, 12'h100, 32'h112233DD, 0, "R5");    do_req(0, 12'h100, 0, 0);
    expect_ev(1, 12'h100, 32'h112233DD, 4'b0001, "R9"); do_req(5, 12'h100, 0, 0);
    expect_ev(6, 12'h100, 0, 0, "R9");               do_rsp(1, 12'h100, 0);
    expect_ev(6, 12'h100, 0, 0, "R9");               do_req(5, 12'h100, 0, 0);
    expect_ev(0, 12'h100, 0, 0, "R9");               do_req(0, 12'h100, 0, 0);

    expect_ev(4, 12'h104, 0, 0, "R5");               do_req(1, 12'h104, 32'h000000EE, 4'b0001);
    expect_ev(3, 12'h104, 32'h556677EE, 0, "R4");    do_rsp(0, 12'h104, 32'h55667788);
    expect_ev(1, 12'h104, 32'h556677EE, 4'b0001, "R8");
    expect_ev(4, 12'h204, 0, 0, "R8");               do_req(1, 12'h204, 32'h12345678, 4'b1100);
    expect_ev(5, 12'h204, 0, 0, "R10");              do_req(6, 12'h204, 0, 0);
    expect_ev(1, 12'h204, 32'h12340000, 4'b1100, "R10");
    expect_ev(0, 12'h204, 0, 0, "R3");               do_req(0, 12'h204, 0, 0);
    do_rsp(1, 12'h104, 0);
    do_rsp(1, 12'h204, 0);
    expect_ev(5, 12'h100, 0, 0, "R10");              do_req(6, 12'h100, 0, 0);

    expect_ev(2, 12'h108, 32'hCAFEF00D, 4'b1111, "R12"); do_req(4, 12'h108, 32'hCAFEF00D, 4'b1111);
    @(negedge clk);
    req_op = 3'd0; req_addr = 12'h108; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin #1; chk(req_ready == 1'b0, "R2 load stall", {31'd0, req_ready}, 0); @(negedge clk); end
    req_op = 3'd1; req_wdata = 32'h1; req_mask = 4'b0001;
    for (int i = 0; i < 3; i++) begin #1; chk(req_ready == 1'b0, "R2 store stall", {31'd0, req_ready}, 0); @(negedge clk); end
    req_valid = 1'b0;
    expect_ev(4, 12'h108, 0, 0, "R4");               do_rsp(0, 12'h108, 32'h99);
    expect_ev(0, 12'h108, 0, 0, "R4");               do_req(0, 12'h108, 0, 0);

    expect_ev(4, 12'h10C, 0, 0, "R7");               do_req(1, 12'h10C, 32'h0000BEEF, 4'b0011);
    expect_ev(1, 12'h10C, 32'h0000BEEF, 4'b0011, "R7");
    expect_ev(2, 12'h10C, 32'h00000001, 4'b0001, "R7"); do_req(4, 12'h10C, 32'h1, 4'b0001);
    expect_ev(4, 12'h10C, 0, 0, "R7");               do_rsp(0, 12'h10C, 0);

    expect_ev(4, 12'h100, 0, 0, "R6");               do_req(2, 12'h100, 32'h000000AB, 4'b0001);
    expect_ev(1, 12'h100, 32'h00CD00AB, 4'b0101, "R6");
    expect_ev(4, 12'h100, 0, 0, "R6");               do_req(3, 12'h100, 32'h00CD0000, 4'b0100);
    expect_ev(0, 12'h100, 0, 0, "R6");               do_req(0, 12'h100, 0, 0);

    @(negedge clk); l1_off = 1'b1;
    expect_ev(1, 12'h108, 32'h77000000, 4'b1000, "R11");
    expect_ev(4, 12'h108, 0, 0, "R11");              do_req(1, 12'h108, 32'h77000000, 4'b1000);
    expect_ev(3, 12'h108, 32'h0BADBEEF, 0, "R11");   do_rsp(0, 12'h108, 32'h0BADBEEF);
    expect_ev(0, 12'h108, 0, 0, "R11");              do_req(0, 12'h108, 0, 0);

    expect_ev(3, 12'h104, 32'hDEAD0001, 0, "R1");
    expect_ev(0, 12'h104, 0, 0, "R1");
    @(negedge clk);
    rsp_wback = 1'b0; rsp_addr = 12'h104; rsp_data = 32'hDEAD0001; rsp_valid = 1'b1;
    req_op = 3'd0; req_addr = 12'h104; req_valid = 1'b1;
    #1 chk(!req_ready && rsp_ready, "R1 priority", {30'd0, req_ready, rsp_ready}, 32'd1);
    @(posedge clk); #1 rsp_valid = 1'b0;
    @(negedge clk); #1 chk(req_ready, "R1 request after response", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1 req_valid = 1'b0;

    @(negedge clk); l1_off = 1'b0;
    expect_ev(3, 12'h104, 32'h01020304, 0, "R8");   do_rsp(0, 12'h104, 32'h01020304);
    expect_ev(4, 12'h204, 0, 0, "R8");               do_req(1, 12'h204, 32'h0, 4'b0001);

    repeat (6) @(negedge clk);
    chk(exp_k.size() == 0, "R1 missing events", exp_k.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule